// File: doc/BRIEF.md
# Delay-Slot-Aware Fetch PC Sequencer

This block forms the fetch group and sequences the program counter for an instruction fetch stage on an architecture with branch delay slots. It holds three address registers: the current fetch address (PC), the following address (NPC) and the one after that (NNPC). Each cycle it receives one cache line of 4-byte instruction words together with a per-slot branch prediction. Each slot's prediction has a control flag, a taken flag, an annul flag and a target. From these it sends up to `FETCH_W` instructions to decode, each with its address, its word and a sequence number.

A predicted-taken branch does not redirect fetch straight away. The block records the target and the branch's sequence number, and keeps fetching until the delay-slot instruction behind the branch has been emitted. Only then does it load the target. A not-taken branch that annuls its delay slot ends the group, and fetch resumes past the slot. Squash requests from later stages reload all three addresses. A squash also drops the pending delay-slot record when it reaches back to or before the recorded branch. While no line is delivered, the block waits with all state held.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: After reset PC equals `RESET_PC`, NPC equals `RESET_PC`+4, NNPC equals `RESET_PC`+8. No decode entry is valid, the miss-wait flag is low and the sequence counter is zero.
- R2: A group starts at line slot PC[log2(LINE_BYTES)-1:2]. Decode entry i carries the address and word of slot start+i and the sequence number base+i. Valid entries are contiguous from entry 0. Outputs appear one clock after the line is accepted.
- R3: A group stops at the last slot of the line or after `FETCH_W` entries, whichever comes first. With no branch involved, the next PC is the address after the last emitted slot.
- R4: A non-control slot, or a not-taken branch without annul, lets the group continue. When no delay slot is pending, NPC equals PC+4 and NNPC equals NPC+4.
- R5: When a predicted-taken branch and its delay slot both fit in the group, the group closes after the delay slot. Then PC equals the target, NPC the target+4 and NNPC the target+8.
- R6: When a predicted-taken branch is the last entry of a group, PC becomes the delay-slot address and NPC the target. The next accepted group emits only the delay slot and then redirects to the target.
- R7: Prediction flags on a slot fetched as a pending delay slot are ignored.
- R8: A not-taken branch with annul set closes the group. PC becomes branch+8 and NPC branch+12.
- R9: A squash loads PC, NPC and NNPC with the squash address, +4 and +8. It emits nothing in that cycle and takes priority over a delivered line.
- R10: A squash with sequence number S clears the pending delay-slot record when S is at most the recorded branch number. Otherwise the record survives and still redirects after the delay slot.
- R11: With no line and no squash, nothing is emitted, the addresses hold, and the miss-wait flag is high in the next cycle. A delivered line or a squash clears the flag.
- R12: The sequence counter advances by the number of entries emitted. It holds across squash and miss cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_valid_i | input | 1 | The line for the current PC is delivered this cycle |
| line_inst_i | input | SLOTS*32 | Instruction words of the line, slot 0 in the low bits |
| pred_ctrl_i | input | SLOTS | Slot holds a control instruction |
| pred_taken_i | input | SLOTS | Slot predicted taken |
| pred_annul_i | input | SLOTS | Slot's not-taken outcome annuls its delay slot |
| pred_target_i | input | SLOTS*32 | Predicted target per slot |
| squash_i | input | 1 | Redirect request from a later stage |
| squash_pc_i | input | 32 | Redirect address |
| squash_seq_i | input | 16 | Sequence number of the squashing instruction |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC |
| nnpc_o | output | 32 | Next-next PC |
| miss_wait_o | output | 1 | Waiting for a line |
| dec_valid_o | output | FETCH_W | Decode entry valid bits |
| dec_inst_o | output | FETCH_W*32 | Decode entry words |
| dec_pc_o | output | FETCH_W*32 | Decode entry addresses |
| dec_seq_o | output | FETCH_W*16 | Decode entry sequence numbers |

## Verification
The assertions assume that the delivered line belongs to the current PC, and that squash addresses and targets are word aligned. The bench builds each line from the address on `pc_o` and uses only aligned redirect addresses. The assertions also assume that at most one delay slot is pending, because the block never lets a delay-slot position start a second branch. The stimulus places taken branches only where this holds, and it puts predictions on a delay-slot position only to confirm they are ignored.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    localparam int ADDR_W     = 32;
    localparam int SEQ_W      = 16;
    localparam int INST_W     = 32;
    localparam int INST_BYTES = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [INST_W-1:0] inst_t;

    // Per-slot prediction delivered with the line
    typedef struct packed {
        logic  ctrl;
        logic  taken;
        logic  annul;
        addr_t target;
    } pred_t;

    // How a slot steers the address sequence
    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_TAKEN = 2'd1,
        K_FALL  = 2'd2,
        K_SKIP  = 2'd3
    } kind_e;

    typedef struct packed {
        addr_t pc;
        addr_t npc;
        addr_t nnpc;
    } pcs_t;

    // Pending delay-slot record
    typedef struct packed {
        logic [1:0] pending;
        logic       ready;
        addr_t      target;
        seq_t       br_seq;
    } dslot_t;

    function automatic kind_e classify(input pred_t p);
        if (!p.ctrl)      return K_PLAIN;
        else if (p.taken) return K_TAKEN;
        else if (p.annul) return K_SKIP;
        else              return K_FALL;
    endfunction

    function automatic addr_t step(input addr_t a, input int n);
        return a + addr_t'(n * INST_BYTES);
    endfunction

    function automatic pcs_t pcs_from(input addr_t a);
        pcs_t r;
        r.pc   = a;
        r.npc  = step(a, 1);
        r.nnpc = step(a, 2);
        return r;
    endfunction

endpackage

// File: rtl/fs_group_former.sv
module fs_group_former
    import fetch_seq_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    parameter int FETCH_W    = 4
) (
    input  logic                          enable,
    input  pcs_t                          cur_pcs,
    input  dslot_t                        cur_rec,
    input  seq_t                          seq_base,
    input  inst_t                         line_inst [LINE_BYTES/INST_BYTES],
    input  pred_t                         line_pred [LINE_BYTES/INST_BYTES],
    output logic [FETCH_W-1:0]            g_valid,
    output inst_t                         g_inst [FETCH_W],
    output addr_t                         g_pc   [FETCH_W],
    output seq_t                          g_seq  [FETCH_W],
    output logic [$clog2(FETCH_W+1)-1:0]  g_count,
    output pcs_t                          nxt_pcs,
    output dslot_t                        nxt_rec
);
    localparam int SLOTS  = LINE_BYTES / INST_BYTES;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int OFF_LG = $clog2(LINE_BYTES);
    localparam int CNT_W  = $clog2(FETCH_W + 1);

    always_comb begin
        addr_t            base;
        addr_t            nx_pc;
        addr_t            nx_npc;
        addr_t            cur;
        dslot_t           rec;
        logic             closed;
        int               cnt;
        int               slot;
        logic [SLOT_W-1:0] start;
        pred_t            p;

        base   = {cur_pcs.pc[ADDR_W-1:OFF_LG], {OFF_LG{1'b0}}};
        start  = cur_pcs.pc[OFF_LG-1:2];
        nx_pc  = cur_pcs.pc;
        nx_npc = cur_pcs.npc;
        rec    = cur_rec;
        closed = !enable;
        cnt    = 0;

        for (int i = 0; i < FETCH_W; i++) begin
            g_valid[i] = 1'b0;
            g_inst[i]  = '0;
            g_pc[i]    = '0;
            g_seq[i]   = seq_base + seq_t'(i);
            slot       = int'(start) + i;
            if (!closed && slot < SLOTS) begin
                cur        = step(base, slot);
                g_valid[i] = 1'b1;
                g_pc[i]    = cur;
                g_inst[i]  = line_inst[SLOT_W'(slot)];
                cnt        = cnt + 1;
                p          = line_pred[SLOT_W'(slot)];
                if (rec.pending != 2'd0) begin
                    // delay slot: its own prediction is not consulted
                    nx_pc       = step(cur, 1);
                    nx_npc      = step(cur, 2);
                    rec.pending = rec.pending - 2'd1;
                    if (rec.pending == 2'd0) begin
                        rec.ready = 1'b1;
                        closed    = 1'b1;
                    end
                end else begin
                    unique case (classify(p))
                        K_TAKEN: begin
                            nx_pc       = nx_npc;
                            nx_npc      = p.target;
                            rec.pending = rec.pending + 2'd1;
                            rec.target  = p.target;
                            rec.br_seq  = seq_base + seq_t'(i);
                        end
                        K_FALL: begin
                            nx_pc  = nx_npc;
                            nx_npc = step(nx_npc, 1);
                        end
                        K_SKIP: begin
                            nx_pc  = step(nx_npc, 1);
                            nx_npc = step(nx_npc, 2);
                            closed = 1'b1;
                        end
                        default: begin
                            nx_pc  = step(cur, 1);
                            nx_npc = step(cur, 2);
                        end
                    endcase
                end
            end
        end

        g_count = CNT_W'(cnt);

        if (!enable) begin
            nxt_pcs = cur_pcs;
            nxt_rec = cur_rec;
        end else if (rec.ready && rec.pending == 2'd0) begin
            nxt_pcs   = pcs_from(rec.target);
            rec.ready = 1'b0;
            nxt_rec   = rec;
        end else begin
            nxt_pcs.pc   = nx_pc;
            nxt_pcs.npc  = nx_npc;
            nxt_pcs.nnpc = step(nx_npc, 1);
            nxt_rec      = rec;
        end
    end

endmodule

// File: rtl/fs_pc_state.sv
module fs_pc_state
    import fetch_seq_pkg::*;
#(
    parameter int    FETCH_W  = 4,
    parameter addr_t RESET_PC = 32'h0000_1000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_valid,
    input  logic                          squash,
    input  addr_t                         squash_pc,
    input  seq_t                          squash_seq,
    input  pcs_t                          nxt_pcs,
    input  dslot_t                        nxt_rec,
    input  logic [$clog2(FETCH_W+1)-1:0]  count,
    output pcs_t                          cur_pcs,
    output dslot_t                        cur_rec,
    output seq_t                          seq_base,
    output logic                          miss_wait
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_pcs   <= pcs_from(RESET_PC);
            cur_rec   <= '0;
            seq_base  <= '0;
            miss_wait <= 1'b0;
        end else if (squash) begin
            cur_pcs   <= pcs_from(squash_pc);
            miss_wait <= 1'b0;
            if (squash_seq <= cur_rec.br_seq) begin
                cur_rec.pending <= '0;
                cur_rec.ready   <= 1'b0;
                cur_rec.target  <= '0;
            end
        end else if (line_valid) begin
            cur_pcs   <= nxt_pcs;
            cur_rec   <= nxt_rec;
            seq_base  <= seq_base + seq_t'(count);
            miss_wait <= 1'b0;
        end else begin
            miss_wait <= 1'b1;
        end
    end

    // R4: without a pending delay slot the three addresses are consecutive
    a_r4_pc_chain: assert property (@(posedge clk) disable iff (rst)
        (cur_rec.pending == 2'd0) |->
            (cur_pcs.npc == step(cur_pcs.pc, 1) && cur_pcs.nnpc == step(cur_pcs.npc, 1)));

    // R12: sequence numbers only move when a line is accepted
    a_r12_seq_hold: assert property (@(posedge clk) disable iff (rst)
        (squash || !line_valid) |=> $stable(seq_base));

endmodule

// File: rtl/fs_dec_out.sv
module fs_dec_out
    import fetch_seq_pkg::*;
#(
    parameter int FETCH_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [FETCH_W-1:0]         g_valid,
    input  inst_t                      g_inst [FETCH_W],
    input  addr_t                      g_pc   [FETCH_W],
    input  seq_t                       g_seq  [FETCH_W],
    output logic [FETCH_W-1:0]         dec_valid,
    output logic [FETCH_W*INST_W-1:0]  dec_inst,
    output logic [FETCH_W*ADDR_W-1:0]  dec_pc,
    output logic [FETCH_W*SEQ_W-1:0]   dec_seq
);

    always_ff @(posedge clk) begin
        if (rst) dec_valid <= '0;
        else     dec_valid <= g_valid;
    end

    for (genvar i = 0; i < FETCH_W; i++) begin : g_lane
        always_ff @(posedge clk) begin
            dec_inst[i*INST_W +: INST_W] <= g_inst[i];
            dec_pc[i*ADDR_W +: ADDR_W]   <= g_pc[i];
            dec_seq[i*SEQ_W +: SEQ_W]    <= g_seq[i];
        end
    end

    // R2: valid lanes are packed toward lane 0
    a_r2_valid_contig: assert property (@(posedge clk) disable iff (rst)
        ((dec_valid >> 1) & ~dec_valid) == '0);

endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer
    import fetch_seq_pkg::*;
#(
    parameter int    LINE_BYTES = 32,
    parameter int    FETCH_W    = 4,
    parameter addr_t RESET_PC   = 32'h0000_1000
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           line_valid_i,
    input  logic [(LINE_BYTES/INST_BYTES)*INST_W-1:0]      line_inst_i,
    input  logic [(LINE_BYTES/INST_BYTES)-1:0]             pred_ctrl_i,
    input  logic [(LINE_BYTES/INST_BYTES)-1:0]             pred_taken_i,
    input  logic [(LINE_BYTES/INST_BYTES)-1:0]             pred_annul_i,
    input  logic [(LINE_BYTES/INST_BYTES)*ADDR_W-1:0]      pred_target_i,
    input  logic                                           squash_i,
    input  logic [ADDR_W-1:0]                              squash_pc_i,
    input  logic [SEQ_W-1:0]                               squash_seq_i,
    output logic [ADDR_W-1:0]                              pc_o,
    output logic [ADDR_W-1:0]                              npc_o,
    output logic [ADDR_W-1:0]                              nnpc_o,
    output logic                                           miss_wait_o,
    output logic [FETCH_W-1:0]                             dec_valid_o,
    output logic [FETCH_W*INST_W-1:0]                      dec_inst_o,
    output logic [FETCH_W*ADDR_W-1:0]                      dec_pc_o,
    output logic [FETCH_W*SEQ_W-1:0]                       dec_seq_o
);
    localparam int SLOTS = LINE_BYTES / INST_BYTES;
    localparam int CNT_W = $clog2(FETCH_W + 1);

    inst_t  line_inst [SLOTS];
    pred_t  line_pred [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign line_inst[s]        = line_inst_i[s*INST_W +: INST_W];
        assign line_pred[s].ctrl   = pred_ctrl_i[s];
        assign line_pred[s].taken  = pred_taken_i[s];
        assign line_pred[s].annul  = pred_annul_i[s];
        assign line_pred[s].target = pred_target_i[s*ADDR_W +: ADDR_W];
    end

    logic               accept;
    pcs_t               cur_pcs;
    pcs_t               nxt_pcs;
    dslot_t             cur_rec;
    dslot_t             nxt_rec;
    seq_t               seq_base;
    logic [FETCH_W-1:0] g_valid;
    inst_t              g_inst [FETCH_W];
    addr_t              g_pc   [FETCH_W];
    seq_t               g_seq  [FETCH_W];
    logic [CNT_W-1:0]   g_count;

    // a squash wins over a delivered line
    assign accept = line_valid_i && !squash_i;

    fs_group_former #(.LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W)) u_former (
        .enable    (accept),
        .cur_pcs   (cur_pcs),
        .cur_rec   (cur_rec),
        .seq_base  (seq_base),
        .line_inst (line_inst),
        .line_pred (line_pred),
        .g_valid   (g_valid),
        .g_inst    (g_inst),
        .g_pc      (g_pc),
        .g_seq     (g_seq),
        .g_count   (g_count),
        .nxt_pcs   (nxt_pcs),
        .nxt_rec   (nxt_rec)
    );

    fs_pc_state #(.FETCH_W(FETCH_W), .RESET_PC(RESET_PC)) u_state (
        .clk        (clk),
        .rst        (rst),
        .line_valid (line_valid_i),
        .squash     (squash_i),
        .squash_pc  (squash_pc_i),
        .squash_seq (squash_seq_i),
        .nxt_pcs    (nxt_pcs),
        .nxt_rec    (nxt_rec),
        .count      (g_count),
        .cur_pcs    (cur_pcs),
        .cur_rec    (cur_rec),
        .seq_base   (seq_base),
        .miss_wait  (miss_wait_o)
    );

    fs_dec_out #(.FETCH_W(FETCH_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .g_valid   (g_valid),
        .g_inst    (g_inst),
        .g_pc      (g_pc),
        .g_seq     (g_seq),
        .dec_valid (dec_valid_o),
        .dec_inst  (dec_inst_o),
        .dec_pc    (dec_pc_o),
        .dec_seq   (dec_seq_o)
    );

    assign pc_o   = cur_pcs.pc;
    assign npc_o  = cur_pcs.npc;
    assign nnpc_o = cur_pcs.nnpc;

    // R9: a squash cycle sends nothing to decode
    a_r9_squash_quiet: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> (dec_valid_o == '0));

    // R9: a squash loads the requested address
    a_r9_squash_load: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> (pc_o == $past(squash_pc_i)));

    // R11: waiting for a line holds the address and emits nothing
    a_r11_miss_hold: assert property (@(posedge clk) disable iff (rst)
        (!line_valid_i && !squash_i) |=> ($stable(pc_o) && dec_valid_o == '0 && miss_wait_o));

    // R11: a delivered line ends the wait
    a_r11_miss_clear: assert property (@(posedge clk) disable iff (rst)
        (line_valid_i || squash_i) |=> !miss_wait_o);

endmodule

// File: tb/fetch_pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module fetch_pc_sequencer_tb_top;
    import fetch_seq_pkg::*;

    localparam int    LINE_BYTES = 32;
    localparam int    FETCH_W    = 4;
    localparam int    SLOTS      = LINE_BYTES / INST_BYTES;
    localparam addr_t RST_PC     = 32'h0000_1000;

    logic                       clk = 1'b0;
    logic                       rst;
    logic                       line_valid_i;
    logic [SLOTS*INST_W-1:0]    line_inst_i;
    logic [SLOTS-1:0]           pred_ctrl_i, pred_taken_i, pred_annul_i;
    logic [SLOTS*ADDR_W-1:0]    pred_target_i;
    logic                       squash_i;
    logic [ADDR_W-1:0]          squash_pc_i;
    logic [SEQ_W-1:0]           squash_seq_i;
    logic [ADDR_W-1:0]          pc_o, npc_o, nnpc_o;
    logic                       miss_wait_o;
    logic [FETCH_W-1:0]         dec_valid_o;
    logic [FETCH_W*INST_W-1:0]  dec_inst_o;
    logic [FETCH_W*ADDR_W-1:0]  dec_pc_o;
    logic [FETCH_W*SEQ_W-1:0]   dec_seq_o;

    always #2 clk = ~clk;

    fetch_pc_sequencer #(.LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W), .RESET_PC(RST_PC)) dut_i (
        .clk(clk), .rst(rst), .line_valid_i(line_valid_i), .line_inst_i(line_inst_i),
        .pred_ctrl_i(pred_ctrl_i), .pred_taken_i(pred_taken_i), .pred_annul_i(pred_annul_i),
        .pred_target_i(pred_target_i), .squash_i(squash_i), .squash_pc_i(squash_pc_i),
        .squash_seq_i(squash_seq_i), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
        .miss_wait_o(miss_wait_o), .dec_valid_o(dec_valid_o), .dec_inst_o(dec_inst_o),
        .dec_pc_o(dec_pc_o), .dec_seq_o(dec_seq_o)
    );

    typedef struct packed {
        logic        v;
        logic [7:0]  ctrl;
        logic [7:0]  tkn;
        logic [7:0]  ann;
        addr_t       tgt;
        logic        sq;
        addr_t       sq_pc;
        seq_t        sq_seq;
        logic [3:0]  cnt;
        addr_t       pc0;
        seq_t        seq0;
        addr_t       pc;
        addr_t       npc;
        logic        miss;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd4, 32'h1000, 16'd0,  32'h1010, 32'h1014, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd4, 32'h1010, 16'd4,  32'h1020, 32'h1024, 1'b0},
        '{1'b1, 8'h02, 8'h02, 8'h00, 32'h2000, 1'b0, 32'h0,    16'd0,  4'd3, 32'h1020, 16'd8,  32'h2000, 32'h2004, 1'b0},
        '{1'b1, 8'h01, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd4, 32'h2000, 16'd11, 32'h2010, 32'h2014, 1'b0},
        '{1'b1, 8'h10, 8'h00, 8'h10, 32'h0,    1'b0, 32'h0,    16'd0,  4'd1, 32'h2010, 16'd15, 32'h2018, 32'h201C, 1'b0},
        '{1'b0, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd0, 32'h0,    16'd0,  32'h2018, 32'h201C, 1'b1},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd2, 32'h2018, 16'd16, 32'h2020, 32'h2024, 1'b0},
        '{1'b1, 8'h08, 8'h08, 8'h00, 32'h3000, 1'b0, 32'h0,    16'd0,  4'd4, 32'h2020, 16'd18, 32'h2030, 32'h3000, 1'b0},
        '{1'b1, 8'h10, 8'h10, 8'h00, 32'h3333, 1'b0, 32'h0,    16'd0,  4'd1, 32'h2030, 16'd22, 32'h3000, 32'h3004, 1'b0},
        '{1'b1, 8'h08, 8'h08, 8'h00, 32'h4000, 1'b0, 32'h0,    16'd0,  4'd4, 32'h3000, 16'd23, 32'h3010, 32'h4000, 1'b0},
        '{1'b1, 8'h01, 8'h01, 8'h00, 32'h4444, 1'b1, 32'h5000, 16'd26, 4'd0, 32'h0,    16'd0,  32'h5000, 32'h5004, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd4, 32'h5000, 16'd27, 32'h5010, 32'h5014, 1'b0},
        '{1'b1, 8'h80, 8'h80, 8'h00, 32'h6000, 1'b0, 32'h0,    16'd0,  4'd4, 32'h5010, 16'd31, 32'h5020, 32'h6000, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b1, 32'h5020, 16'd35, 4'd0, 32'h0,    16'd0,  32'h5020, 32'h5024, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd1, 32'h5020, 16'd35, 32'h6000, 32'h6004, 1'b0},
        '{1'b0, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd0, 32'h0,    16'd0,  32'h6000, 32'h6004, 1'b1},
        '{1'b0, 8'h00, 8'h00, 8'h00, 32'h0,    1'b1, 32'h7000, 16'd0,  4'd0, 32'h0,    16'd0,  32'h7000, 32'h7004, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 32'h0,    1'b0, 32'h0,    16'd0,  4'd4, 32'h7000, 16'd36, 32'h7010, 32'h7014, 1'b0}
    };

    int n_run  = 0;
    int n_fail = 0;

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R2";
            1, 6:    return "R3";
            2:       return "R5";
            3:       return "R4";
            4:       return "R8";
            7, 9:    return "R6";
            8:       return "R7";
            10, 13:  return "R9";
            11, 14:  return "R10";
            5, 15, 16: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_line(input vec_t v);
        addr_t base;
        base = {pc_o[ADDR_W-1:5], 5'b0};
        for (int s = 0; s < SLOTS; s++) begin
            line_inst_i[s*INST_W +: INST_W]   = {16'hC0DE, 16'(base + addr_t'(s*4))};
            pred_target_i[s*ADDR_W +: ADDR_W] = v.tgt;
        end
        line_valid_i  = v.v;
        pred_ctrl_i   = v.ctrl;
        pred_taken_i  = v.tkn;
        pred_annul_i  = v.ann;
        squash_i      = v.sq;
        squash_pc_i   = v.sq_pc;
        squash_seq_i  = v.sq_seq;
    endtask

    task automatic check_reset_state();
        check("R1", "pc",    64'(pc_o),        64'(RST_PC));
        check("R1", "npc",   64'(npc_o),       64'(RST_PC + 32'd4));
        check("R1", "nnpc",  64'(nnpc_o),      64'(RST_PC + 32'd8));
        check("R1", "valid", 64'(dec_valid_o), 64'd0);
        check("R1", "miss",  64'(miss_wait_o), 64'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        line_valid_i = 1'b0; line_inst_i = '0; pred_ctrl_i = '0; pred_taken_i = '0;
        pred_annul_i = '0; pred_target_i = '0; squash_i = 1'b0; squash_pc_i = '0; squash_seq_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            string t;
            v = VECS[i];
            t = tag_of(i);
            drive_line(v);
            @(negedge clk);
            check(t, "count", 64'($countones(dec_valid_o)), 64'(v.cnt));
            check(t, "pc",    64'(pc_o),  64'(v.pc));
            check(t, "npc",   64'(npc_o), 64'(v.npc));
            check(t, "miss",  64'(miss_wait_o), 64'(v.miss));
            if (v.cnt != 0) begin
                check(t, "pc0",   64'(dec_pc_o[ADDR_W-1:0]), 64'(v.pc0));
                check("R12", "seq0", 64'(dec_seq_o[SEQ_W-1:0]), 64'(v.seq0));
                check(t, "inst0", 64'(dec_inst_o[INST_W-1:0]), 64'({16'hC0DE, v.pc0[15:0]}));
                check(t, "pclast", 64'(dec_pc_o[(v.cnt-1)*ADDR_W +: ADDR_W]),
                      64'(v.pc0 + 32'((v.cnt - 1) * 4)));
                check("R12", "seqlast", 64'(dec_seq_o[(v.cnt-1)*SEQ_W +: SEQ_W]),
                      64'(v.seq0 + 16'(v.cnt - 1)));
            end
        end

        // directed: reset in mid-run returns to the reset state
        rst = 1'b1;
        line_valid_i = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        line_valid_i = 1'b0;
        check_reset_state();

        // directed: sequence restarts at zero after reset (R12)
        drive_line(VECS[0]);
        @(negedge clk);
        check("R12", "seq after reset", 64'(dec_seq_o[SEQ_W-1:0]), 64'd0);
        check("R3", "pc after reset fetch", 64'(pc_o), 64'(RST_PC + 32'h10));

        finish_run();
    end

endmodule